// File: doc/BRIEF.md
# Wishbone to asynchronous SRAM-style bridge

This block is a Wishbone slave that turns each bus cycle into a single access on an external asynchronous port, as used by SRAM and by slow to mid-speed peripheral chips. The external port has a registered address, a bidirectional data bus, and active-low strobes for chip select, read, write and the byte lanes. The data and address widths are compile-time parameters. The length of each access is set at run time by a 4-bit wait-state input.

Every access is followed by one idle cycle in which all strobes are released. That cycle comes after the acknowledge, so it never delays a following bus cycle to another slave. Accesses to this block can run back to back, but at most once every two clocks. The acknowledge and the read data join a daisy chain: the upstream chain inputs are ORed with this block's own contribution. Several slaves can therefore drive one return path without a multiplexer. Single, block and read-modify-write cycles are all sequences of these accesses.

Top module: `wab_bridge`

## Requirements
- R1: While rst_ni is low, and in idle afterwards, ext_cs_no, ext_rd_no and ext_wr_no are 1, every bit of ext_be_no is 1, and the bridge adds no acknowledge of its own.
- R2: If the wait value is N (0..15) when an access starts, ext_cs_no stays low for exactly N+1 cycles. The bridge's own acknowledge is high only in the last of those cycles.
- R3: In the cycle after each access, all strobes are high and the bridge's own acknowledge is 0. The acknowledge itself is never delayed into that idle cycle.
- R4: A strobe present during the idle cycle starts a new access on the next clock edge, so back-to-back accesses are separated by exactly one cycle with ext_cs_no high.
- R5: A write access (we_i = 1) holds ext_wr_no low and ext_rd_no high, drives ext_data_io with dat_i, and presents ext_be_no = ~sel_i (bit k covers data bits 8k+7..8k).
- R6: A read access holds ext_rd_no low and ext_wr_no high and leaves ext_data_io undriven. In the acknowledge cycle, dat_o carries the value on ext_data_io ORed with dat_chain_i.
- R7: Address, write data, byte enables, direction and wait count are captured when the access starts and stay stable for all of it, even if the bus inputs change.
- R8: ack_o = ack_chain_i OR the bridge's own acknowledge. dat_o = dat_chain_i OR the bridge's read data. The bridge's data contribution is all zeros on writes and whenever it is not acknowledging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 4 | Extra active cycles per access |
| stb_i | input | 1 | Cycle addressed to this slave |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | DATA_W/8 | Byte lane selects |
| adr_i | input | ADDR_W | Bus address |
| dat_i | input | DATA_W | Write data from master |
| dat_o | output | DATA_W | Read data, merged with chain |
| ack_o | output | 1 | Acknowledge, merged with chain |
| ack_chain_i | input | 1 | Upstream acknowledge chain |
| dat_chain_i | input | DATA_W | Upstream read data chain |
| ext_data_io | inout | DATA_W | External data bus |
| ext_addr_o | output | ADDR_W | External address |
| ext_rd_no | output | 1 | Read strobe, active low |
| ext_wr_no | output | 1 | Write strobe, active low |
| ext_cs_no | output | 1 | Chip select, active low |
| ext_be_no | output | DATA_W/8 | Byte enables, active low |

## Verification
When the clock edge samples a strobe from idle or from the idle cycle, the external strobes fall right after that edge. The acknowledge comes combinationally in the (N+1)th active cycle, and the strobes rise on the edge that completes the transfer. Chain inputs reach ack_o and dat_o in the same cycle. The bench changes inputs and samples outputs only on falling edges. Its monitor follows chip select cycle by cycle and compares each active cycle, each acknowledge and each run length against the item the driver queued for that access.

// File: rtl/wab_pkg.sv
package wab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DEACT  = 2'd2
  } wab_state_e;
endpackage

// File: rtl/wab_ctrl.sv
module wab_ctrl
  import wab_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              start_o,
  output logic              active_o,
  output logic              last_o
);
  wab_state_e        st_q, st_d;
  logic [WAIT_W-1:0] cnt_q;

  // a new access may start from idle or from the deactivation cycle
  assign start_o  = stb_i && (st_q != ST_ACCESS);
  assign active_o = (st_q == ST_ACCESS);
  assign last_o   = active_o && (cnt_q == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (stb_i) st_d = ST_ACCESS;
      ST_ACCESS: if (last_o) st_d = ST_DEACT;
      ST_DEACT:  st_d = stb_i ? ST_ACCESS : ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_o)                      cnt_q <= wait_i;
      else if (active_o && !last_o)     cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wab_hold.sv
module wab_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              we_o,
  output logic [SEL_W-1:0]  be_no,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o  <= 1'b0;
      be_no <= '1;
      adr_o <= '0;
      dat_o <= '0;
    end else if (start_i) begin
      we_o  <= we_i;
      be_no <= ~sel_i;
      adr_o <= adr_i;
      dat_o <= dat_i;
    end
  end
endmodule

// File: rtl/wab_merge.sv
module wab_merge #(
  parameter int DATA_W = 32
) (
  input  logic              own_ack_i,
  input  logic              own_we_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              ack_chain_i,
  input  logic [DATA_W-1:0] dat_chain_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o
);
  logic [DATA_W-1:0] own_dat;

  assign own_dat = (own_ack_i && !own_we_i) ? bus_i : '0;
  assign ack_o   = ack_chain_i | own_ack_i;
  assign dat_o   = dat_chain_i | own_dat;
endmodule

// File: rtl/wab_bridge.sv
module wab_bridge #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack_o,
  input  logic              ack_chain_i,
  input  logic [DATA_W-1:0] dat_chain_i,
  inout  wire  [DATA_W-1:0] ext_data_io,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              ext_rd_no,
  output logic              ext_wr_no,
  output logic              ext_cs_no,
  output logic [SEL_W-1:0]  ext_be_no
);
  logic              start, active, last;
  logic              we_q;
  logic [SEL_W-1:0]  be_n_q;
  logic [DATA_W-1:0] wdat_q;

  wab_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (stb_i),
    .wait_i  (wait_i),
    .start_o (start),
    .active_o(active),
    .last_o  (last)
  );

  wab_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .we_i   (we_i),
    .sel_i  (sel_i),
    .adr_i  (adr_i),
    .dat_i  (dat_i),
    .we_o   (we_q),
    .be_no  (be_n_q),
    .adr_o  (ext_addr_o),
    .dat_o  (wdat_q)
  );

  wab_merge #(.DATA_W(DATA_W)) u_merge (
    .own_ack_i  (last),
    .own_we_i   (we_q),
    .bus_i      (ext_data_io),
    .ack_chain_i(ack_chain_i),
    .dat_chain_i(dat_chain_i),
    .ack_o      (ack_o),
    .dat_o      (dat_o)
  );

  assign ext_cs_no   = !active;
  assign ext_rd_no   = !(active && !we_q);
  assign ext_wr_no   = !(active && we_q);
  assign ext_be_no   = active ? be_n_q : '1;
  assign ext_data_io = (active && we_q) ? wdat_q : 'z;
endmodule

// File: rtl/wab_bridge_chk.sv
module wab_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int SEL_W = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic [DATA_W-1:0] dat_o,
  input logic              ack_chain_i,
  input logic [DATA_W-1:0] dat_chain_i,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic              ext_rd_no,
  input logic              ext_wr_no,
  input logic              ext_cs_no,
  input logic [SEL_W-1:0]  ext_be_no
);
  AST_IDLE_BE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cs_no |-> (&ext_be_no && ext_rd_no && ext_wr_no)); // R1

  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_cs_no |-> (ext_rd_no != ext_wr_no)); // R5

  AST_DEACT_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_cs_no && ack_o && !ack_chain_i) |=> ext_cs_no); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_cs_no |=> (ext_cs_no || ($stable(ext_addr_o) && $stable(ext_be_no)
                                  && $stable(ext_wr_no)))); // R7

  AST_CHAIN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cs_no |-> (ack_o == ack_chain_i && dat_o == dat_chain_i)); // R8
endmodule

bind wab_bridge wab_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wab_bridge_test.sv
module wab_bridge_test;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int SW = DW / 8;

  typedef struct {
    logic          we;
    logic [AW-1:0] adr;
    logic [DW-1:0] wdat;
    logic [SW-1:0] be_n;
    int            ws;
    logic [DW-1:0] rdat;
    logic          b2b;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    wait_i = '0;
  logic          stb_i = 1'b0, we_i = 1'b0;
  logic [SW-1:0] sel_i = '0;
  logic [AW-1:0] adr_i = '0;
  logic [DW-1:0] dat_i = '0;
  logic [DW-1:0] dat_o;
  logic          ack_o;
  logic          ack_chain_i = 1'b0;
  logic [DW-1:0] dat_chain_i = '0;
  wire  [DW-1:0] ext_data;
  logic [AW-1:0] ext_addr_o;
  logic          ext_rd_no, ext_wr_no, ext_cs_no;
  logic [SW-1:0] ext_be_no;

  int total = 0, bad = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  item_t cur;
  int run = 0, hi_run = 0;

  always #4 clk_i = ~clk_i;

  function automatic logic [DW-1:0] dev_f(logic [AW-1:0] a);
    return {~a, a ^ 16'h3C5A};
  endfunction

  // external device: answers reads with an address-derived word
  assign ext_data = !ext_rd_no ? dev_f(ext_addr_o) : 'z;

  wab_bridge #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(wait_i), .stb_i(stb_i), .we_i(we_i),
    .sel_i(sel_i), .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
    .ack_chain_i(ack_chain_i), .dat_chain_i(dat_chain_i), .ext_data_io(ext_data),
    .ext_addr_o(ext_addr_o), .ext_rd_no(ext_rd_no), .ext_wr_no(ext_wr_no),
    .ext_cs_no(ext_cs_no), .ext_be_no(ext_be_no)
  );

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: queue the expected access, hold the cycle until acknowledged
  task automatic xfer(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s,
                      int ws, logic b2b, logic scr);
    item_t it;
    it.we = we; it.adr = a; it.wdat = d; it.be_n = ~s; it.ws = ws;
    it.rdat = dev_f(a); it.b2b = b2b;
    exp_q.push_back(it);
    stb_i = 1'b1; we_i = we; adr_i = a; dat_i = d; sel_i = s; wait_i = 4'(ws);
    do begin
      @(negedge clk_i);
      if (scr && !ack_o) begin
        adr_i = ~adr_i; dat_i = ~dat_i; sel_i = ~sel_i; wait_i = 4'd0; we_i = ~we_i;
      end
    end while (!ack_o);
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    stb_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: follows chip select and compares against queued items
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!ext_cs_no) begin
        if (run == 0) begin
          if (exp_q.size() == 0) chk("R2", "access without request", 1, 0);
          else begin
            cur = exp_q.pop_front();
            if (cur.b2b) chk("R4", "idle gap before back-to-back", DW'(hi_run), 1);
          end
        end
        chk("R7", "address", DW'(ext_addr_o), DW'(cur.adr));
        chk("R7", "byte enables", DW'(ext_be_no), DW'(cur.be_n));
        chk(cur.we ? "R5" : "R6", "write strobe", DW'(ext_wr_no), DW'(!cur.we));
        chk(cur.we ? "R5" : "R6", "read strobe", DW'(ext_rd_no), DW'(cur.we));
        if (cur.we) chk("R5", "bus write data", ext_data, cur.wdat);
        chk("R2", "ack timing", DW'(ack_o), DW'(run == cur.ws));
        if (ack_o) begin
          if (cur.we) chk("R8", "write returns chain data", dat_o, dat_chain_i);
          else        chk("R6", "read data", dat_o, cur.rdat | dat_chain_i);
        end
        run++;
        hi_run = 0;
      end else begin
        if (run != 0) begin
          chk("R2", "active length", DW'(run), DW'(cur.ws + 1));
          chk("R3", "no own ack in idle cycle", DW'(ack_o), DW'(ack_chain_i));
          chk("R3", "strobes released", DW'({ext_rd_no, ext_wr_no}), DW'(2'b11));
          run = 0;
        end
        hi_run++;
      end
    end
  end

  initial begin
    #(8 * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    stb_i = 1'b1; // ignored during reset
    @(negedge clk_i);
    chk("R1", "cs in reset", DW'(ext_cs_no), 1);
    chk("R1", "rd/wr in reset", DW'({ext_rd_no, ext_wr_no}), DW'(2'b11));
    chk("R1", "be in reset", DW'(ext_be_no), DW'({SW{1'b1}}));
    chk("R1", "ack in reset", DW'(ack_o), 0);
    stb_i = 1'b0;
    rst_ni = 1'b1;
    idle(2);
    chk("R1", "cs idle", DW'(ext_cs_no), 1);

    xfer(1'b1, 16'h0010, 32'hDEAD_BEEF, 4'b1111, 0, 1'b0, 1'b0);
    idle(2);
    xfer(1'b0, 16'h0011, '0, 4'b1111, 0, 1'b0, 1'b0);
    idle(1);
    xfer(1'b1, 16'h1234, 32'hA5A5_0F0F, 4'b0101, 3, 1'b0, 1'b0);
    xfer(1'b0, 16'h1234, '0, 4'b0011, 3, 1'b1, 1'b0);
    idle(3);
    xfer(1'b1, 16'hFFFF, 32'h0123_4567, 4'b1000, 15, 1'b0, 1'b0);
    idle(2);
    xfer(1'b0, 16'h0A0A, '0, 4'b0110, 6, 1'b0, 1'b1);
    idle(2);
    xfer(1'b1, 16'h0B0B, 32'h5555_AAAA, 4'b1010, 4, 1'b0, 1'b1);
    idle(2);
    // block read then read-modify-write, all back to back
    xfer(1'b0, 16'h0100, '0, 4'b1111, 0, 1'b0, 1'b0);
    xfer(1'b0, 16'h0101, '0, 4'b1111, 0, 1'b1, 1'b0);
    xfer(1'b0, 16'h0102, '0, 4'b1111, 1, 1'b1, 1'b0);
    xfer(1'b1, 16'h0102, 32'hCAFE_F00D, 4'b0001, 1, 1'b1, 1'b0);
    idle(2);

    // chain passthrough while idle
    ack_chain_i = 1'b1; dat_chain_i = 32'h1357_9BDF;
    #1;
    chk("R8", "chain ack idle", DW'(ack_o), 1);
    chk("R8", "chain data idle", dat_o, 32'h1357_9BDF);
    ack_chain_i = 1'b0; dat_chain_i = 32'h0F00_0000;
    #1;
    chk("R8", "chain ack low idle", DW'(ack_o), 0);
    chk("R8", "chain data idle 2", dat_o, 32'h0F00_0000);
    @(negedge clk_i);
    xfer(1'b0, 16'h2222, '0, 4'b1111, 2, 1'b0, 1'b0);
    xfer(1'b1, 16'h2223, 32'h8000_0001, 4'b1100, 0, 1'b1, 1'b0);
    idle(4);
    dat_chain_i = '0;

    chk("R2", "all queued accesses seen", DW'(exp_q.size()), 0);
    chk("R1", "idle after traffic", DW'({ext_cs_no, ext_rd_no, ext_wr_no}), DW'(3'b111));
    finish_run();
  end
endmodule